// File: doc/BRIEF.md
# Split-Word Single-Slot Mailbox

This block passes 32-bit messages between a host processor and a DSP through a small set of one-deep mailboxes. Each side has its own 16-bit register port with separate write and read strobes. Because the port is 16 bits wide, every message crosses it in two halves. The low half goes into a data register and the high half into a command register.

The sender writes the data half and then the command half. The command write is the commit event: it raises the mailbox's pending flag and drives the receiver's interrupt line. The receiver reads the data half and then the command half, and puts them together as {command, data}. The command read is the consume event: it clears the flag and drops the interrupt.

By default there is one mailbox from host to DSP and two from DSP to host. Interrupts go only to the receiving side of each mailbox. The sender gets no interrupt and no empty indication. The only status either side can see is the pending flag.

Top module: `split_word_mailbox`

## Requirements
- R1: While reset is asserted at a clock edge, all pending flags, both interrupt vectors and both read-data outputs are cleared to zero at that edge.
- R2: Address map (byte addresses, registers on a 4-byte stride):
  - Mailbox s has its data register at 8*s and its command register at 8*s+4.
  - Mailbox 0 carries host-to-DSP messages. Mailboxes 1 and 2 carry DSP-to-host messages.
  - A message's bits [15:0] live in the data register and bits [31:16] in the command register.
- R3: A command-register write by the sending side stores the half and sets that mailbox's flag at the same clock edge. The receiver's interrupt bit goes high from that edge on:
  - dsp_irq[0] belongs to mailbox 0.
  - host_irq[k] belongs to mailbox k+1.
  - A write never raises an interrupt toward its own sender.
- R4: A command-register read by the receiving side returns the command half on rdata one clock after the read strobe. At that same edge it clears the flag and deasserts the interrupt.
- R5: A data-register read, by either side, changes no flag and no interrupt.
- R6: A command write to a mailbox whose flag is already set replaces the stored half and leaves the flag and the interrupt set. The receiver then reads the latest message.
- R7: Writes to a mailbox's data or command register from the side that does not send into it are ignored. The stored halves, the flag and the interrupt are unchanged.
- R8: A command-register read by the sending side returns the stored half and leaves the flag set.
- R9: If a commit by the sender and a consume by the receiver hit the same mailbox at the same edge:
  - the receiver reads the old command half;
  - the flag stays set;
  - the new half is stored.
- R10: The flag register of mailbox s is at 0x18+4*s and can be read from both sides. It reads 1 in bit 0 while a message is pending and 0 otherwise. Bits [15:1] always read 0.
- R11: The following accesses have no effect on any state:
  - addresses that are not a multiple of 4;
  - addresses at or above 0x24;
  - writes to the flag registers.
  Reads of unaligned or out-of-map addresses return 0.
- R12: Each side's rdata holds its last read value on every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | HALF_W | Host write data |
| host_rdata | output | HALF_W | Host read data, valid one cycle after host_rd |
| host_irq | output | N_TO_HOST | Per-mailbox message-waiting interrupts toward the host |
| dsp_addr | input | ADDR_W | DSP byte address |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wdata | input | HALF_W | DSP write data |
| dsp_rdata | output | HALF_W | DSP read data, valid one cycle after dsp_rd |
| dsp_irq | output | N_TO_DSP | Per-mailbox message-waiting interrupts toward the DSP |

## Verification
The bench builds the block with its default parameters: 16-bit halves, a 6-bit address, one host-to-DSP mailbox and two DSP-to-host mailboxes. With these values the whole 64-address space can be read back after reset, and every mailbox can be driven from its sending side and drained from its receiving side with several computed message patterns.

The small address space also brings the other cases within reach:
- hits from the wrong side;
- unaligned and out-of-map accesses;
- overwrite while pending;
- commit and consume in the same cycle.

// File: rtl/mbx_pkg.sv
// Shared types and address decoding for the split-word mailbox.
// Assumes registers sit on a 4-byte stride: all data/command pairs come
// first, then one flag register per mailbox.
package mbx_pkg;

    localparam int SLOT_IDX_W = 8;

    typedef enum logic [1:0] {
        AREA_NONE = 2'd0,
        AREA_DATA = 2'd1,
        AREA_CMD  = 2'd2,
        AREA_FLAG = 2'd3
    } mbx_area_e;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_DSP  = 1'b1
    } mbx_side_e;

    typedef struct packed {
        mbx_area_e             area;
        logic [SLOT_IDX_W-1:0] slot;
    } mbx_hit_t;

    // Map a byte address onto a register area and mailbox index.
    function automatic mbx_hit_t mbx_decode(input logic [15:0] addr, input int n_slots);
        mbx_hit_t h;
        int       idx;
        h.area = AREA_NONE;
        h.slot = '0;
        idx    = int'(addr[15:2]);
        if (addr[1:0] == 2'b00) begin
            if (idx < 2 * n_slots) begin
                h.slot = SLOT_IDX_W'(idx / 2);
                h.area = (idx % 2 == 1) ? AREA_CMD : AREA_DATA;
            end else if (idx < 3 * n_slots) begin
                h.area = AREA_FLAG;
                h.slot = SLOT_IDX_W'(idx - 2 * n_slots);
            end
        end
        return h;
    endfunction

    // The host sends into the lowest n_to_dsp mailboxes; the DSP sends into the rest.
    function automatic mbx_side_e slot_sender(input int slot, input int n_to_dsp);
        return (slot < n_to_dsp) ? SIDE_HOST : SIDE_DSP;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
// Decodes one side's register access into per-mailbox strobes.
// Only the sending side of a mailbox may write it. Only the receiving
// side consumes it, by reading its command register.
// Assumes the address, wr and rd are stable at the sampling clock edge.
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int        ADDR_W   = 6,
    parameter int        N_SLOTS  = 3,
    parameter int        N_TO_DSP = 1,
    parameter mbx_side_e SIDE     = SIDE_HOST
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    output logic [N_SLOTS-1:0] wr_data_o,
    output logic [N_SLOTS-1:0] wr_cmd_o,
    output logic [N_SLOTS-1:0] consume_o,
    output mbx_hit_t           hit_o
);

    logic [15:0] addr_ext;

    // Widen the address and decode it once for the whole port.
    assign addr_ext = 16'(addr);
    assign hit_o    = mbx_decode(addr_ext, N_SLOTS);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        localparam mbx_side_e SENDER = slot_sender(s, N_TO_DSP);
        localparam bit        I_SEND = (SENDER == SIDE);
        logic sel;

        // Per-mailbox hit and ownership-gated strobes.
        assign sel          = (hit_o.slot == SLOT_IDX_W'(s));
        assign wr_data_o[s] = I_SEND && wr && sel && (hit_o.area == AREA_DATA);
        assign wr_cmd_o[s]  = I_SEND && wr && sel && (hit_o.area == AREA_CMD);
        assign consume_o[s] = !I_SEND && rd && sel && (hit_o.area == AREA_CMD);
    end

endmodule

// File: rtl/mbx_slot.sv
// One single-message mailbox: a data half, a command half and a pending flag.
// A commit wins over a consume in the same cycle, so the new message stays pending.
module mbx_slot #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_cmd,
    input  logic              consume,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] data_q,
    output logic [HALF_W-1:0] cmd_q,
    output logic              pending_q
);

    // Store the halves and track whether a message waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            cmd_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_cmd)       pending_q <= 1'b1;
            else if (consume) pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mbx_read_port.sv
// Registered read path for one side.
// Selects data, command or flag by the decoded hit. Unmapped hits read 0.
// The output holds its value until the next read strobe.
module mbx_read_port
    import mbx_pkg::*;
#(
    parameter int N_SLOTS = 3,
    parameter int HALF_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd,
    input  mbx_hit_t                       hit,
    input  logic [N_SLOTS-1:0][HALF_W-1:0] data_all,
    input  logic [N_SLOTS-1:0][HALF_W-1:0] cmd_all,
    input  logic [N_SLOTS-1:0]             pending,
    output logic [HALF_W-1:0]              rdata_q
);

    logic [HALF_W-1:0] sel_val;

    // Pick the addressed register.
    always_comb begin
        sel_val = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (hit.slot == SLOT_IDX_W'(s)) begin
                case (hit.area)
                    AREA_DATA: sel_val = data_all[s];
                    AREA_CMD:  sel_val = cmd_all[s];
                    AREA_FLAG: sel_val = HALF_W'(pending[s]);
                    default:   sel_val = '0;
                endcase
            end
        end
    end

    // Capture the selected value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= sel_val;
    end

endmodule

// File: rtl/split_word_mailbox.sv
// Top of the split-word mailbox.
// Holds N_TO_DSP host-to-DSP mailboxes followed by N_TO_HOST DSP-to-host
// mailboxes, reachable from two 16-bit register ports.
// Each receiver sees one interrupt bit per incoming mailbox.
// Assumes both ports share one clock.
module split_word_mailbox
    import mbx_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int ADDR_W    = 6,
    parameter int N_TO_DSP  = 1,
    parameter int N_TO_HOST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [HALF_W-1:0]    host_wdata,
    output logic [HALF_W-1:0]    host_rdata,
    output logic [N_TO_HOST-1:0] host_irq,
    input  logic [ADDR_W-1:0]    dsp_addr,
    input  logic                 dsp_wr,
    input  logic                 dsp_rd,
    input  logic [HALF_W-1:0]    dsp_wdata,
    output logic [HALF_W-1:0]    dsp_rdata,
    output logic [N_TO_DSP-1:0]  dsp_irq
);

    localparam int N_SLOTS = N_TO_DSP + N_TO_HOST;

    logic [N_SLOTS-1:0]             h_wr_data, h_wr_cmd, h_consume;
    logic [N_SLOTS-1:0]             d_wr_data, d_wr_cmd, d_consume;
    mbx_hit_t                       h_hit, d_hit;
    logic [N_SLOTS-1:0][HALF_W-1:0] data_all, cmd_all;
    logic [N_SLOTS-1:0]             pending;

    mbx_port_decode #(
        .ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS), .N_TO_DSP(N_TO_DSP), .SIDE(SIDE_HOST)
    ) u_host_dec (
        .addr(host_addr), .wr(host_wr), .rd(host_rd),
        .wr_data_o(h_wr_data), .wr_cmd_o(h_wr_cmd), .consume_o(h_consume), .hit_o(h_hit)
    );

    mbx_port_decode #(
        .ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS), .N_TO_DSP(N_TO_DSP), .SIDE(SIDE_DSP)
    ) u_dsp_dec (
        .addr(dsp_addr), .wr(dsp_wr), .rd(dsp_rd),
        .wr_data_o(d_wr_data), .wr_cmd_o(d_wr_cmd), .consume_o(d_consume), .hit_o(d_hit)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_mbx
        logic [HALF_W-1:0] slot_wdata;

        // The sending side's write bus feeds this mailbox.
        if (s < N_TO_DSP) begin : g_to_dsp
            assign slot_wdata = host_wdata;
            assign dsp_irq[s] = pending[s];
        end else begin : g_to_host
            assign slot_wdata            = dsp_wdata;
            assign host_irq[s-N_TO_DSP]  = pending[s];
        end

        mbx_slot #(.HALF_W(HALF_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_data  (h_wr_data[s] | d_wr_data[s]),
            .wr_cmd   (h_wr_cmd[s]  | d_wr_cmd[s]),
            .consume  (h_consume[s] | d_consume[s]),
            .wdata    (slot_wdata),
            .data_q   (data_all[s]),
            .cmd_q    (cmd_all[s]),
            .pending_q(pending[s])
        );
    end

    mbx_read_port #(.N_SLOTS(N_SLOTS), .HALF_W(HALF_W)) u_host_rd (
        .clk(clk), .rst_n(rst_n), .rd(host_rd), .hit(h_hit),
        .data_all(data_all), .cmd_all(cmd_all), .pending(pending), .rdata_q(host_rdata)
    );

    mbx_read_port #(.N_SLOTS(N_SLOTS), .HALF_W(HALF_W)) u_dsp_rd (
        .clk(clk), .rst_n(rst_n), .rd(dsp_rd), .hit(d_hit),
        .data_all(data_all), .cmd_all(cmd_all), .pending(pending), .rdata_q(dsp_rdata)
    );

endmodule

// File: rtl/mbx_checker.sv
// Protocol checker for split_word_mailbox.
// Sees only the top-level ports and rebuilds commit and consume events
// from the address and the strobes.
module mbx_checker #(
    parameter int HALF_W    = 16,
    parameter int ADDR_W    = 6,
    parameter int N_TO_DSP  = 1,
    parameter int N_TO_HOST = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    host_addr,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [HALF_W-1:0]    host_rdata,
    input logic [N_TO_HOST-1:0] host_irq,
    input logic [ADDR_W-1:0]    dsp_addr,
    input logic                 dsp_wr,
    input logic                 dsp_rd,
    input logic [HALF_W-1:0]    dsp_rdata,
    input logic [N_TO_DSP-1:0]  dsp_irq
);

    localparam int N_SLOTS = N_TO_DSP + N_TO_HOST;

    logic [N_SLOTS-1:0] commit_v, consume_v, irq_v;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_chk
        localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(8 * s + 4);

        if (s < N_TO_DSP) begin : g_to_dsp
            assign commit_v[s]  = host_wr && (host_addr == CMD_A);
            assign consume_v[s] = dsp_rd  && (dsp_addr  == CMD_A);
            assign irq_v[s]     = dsp_irq[s];
        end else begin : g_to_host
            assign commit_v[s]  = dsp_wr  && (dsp_addr  == CMD_A);
            assign consume_v[s] = host_rd && (host_addr == CMD_A);
            assign irq_v[s]     = host_irq[s-N_TO_DSP];
        end

        assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            commit_v[s] |=> irq_v[s]);

        assert_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (consume_v[s] && !commit_v[s]) |=> !irq_v[s]);

        assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!commit_v[s] && !consume_v[s]) |=> $stable(irq_v[s]));

        assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_v[s] && consume_v[s]) |=> irq_v[s]);
    end

    assert_host_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    assert_dsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_rd |=> $stable(dsp_rdata));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (host_irq == '0 && dsp_irq == '0 && host_rdata == '0 && dsp_rdata == '0));

endmodule

bind split_word_mailbox mbx_checker #(
    .HALF_W(HALF_W), .ADDR_W(ADDR_W), .N_TO_DSP(N_TO_DSP), .N_TO_HOST(N_TO_HOST)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .dsp_addr(dsp_addr), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
    .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq)
);

// File: tb/split_word_mailbox_tb.sv
`timescale 1ns/1ps
module split_word_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [1:0]  host_irq;
    logic [5:0]  dsp_addr = '0;
    logic        dsp_wr = 1'b0, dsp_rd = 1'b0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;
    logic [0:0]  dsp_irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    split_word_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .dsp_addr(dsp_addr), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One access on one side; side 0 = host, 1 = DSP. Read data returned after the edge.
    task automatic bus(input bit side, input bit wr, input logic [5:0] a,
                       input logic [15:0] wd, output logic [15:0] rv);
        @(negedge clk);
        if (side == 1'b0) begin
            host_addr = a; host_wdata = wd; host_wr = wr; host_rd = !wr;
        end else begin
            dsp_addr = a; dsp_wdata = wd; dsp_wr = wr; dsp_rd = !wr;
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; dsp_wr = 1'b0; dsp_rd = 1'b0;
        rv = (side == 1'b0) ? host_rdata : dsp_rdata;
    endtask

    function automatic logic [31:0] msg_of(input int s, input int p);
        return {16'(32'hC000 + s * 291 + p * 4369), 16'(32'h5A5A ^ (p << (4 * s)) ^ (s * 7))};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        logic [31:0] m, a_msg, b_msg, c_msg, d_msg;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irqs", {host_irq, dsp_irq}, 0);
        chk("R1 host_rdata", host_rdata, 0);
        chk("R1 dsp_rdata", dsp_rdata, 0);
        // R1/R11: whole address space reads zero after reset
        for (int a = 0; a < 64; a++) begin
            bus(1'b0, 1'b0, 6'(a), 16'h0, rv);
            chk("R1 R11 sweep", rv, 0);
        end

        // R2 R3 R4 R5 R8 R10: every mailbox, several patterns
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                bit snd, rcv;
                logic [5:0] da, ca, fa;
                snd = (s == 0) ? 1'b0 : 1'b1;
                rcv = !snd;
                da = 6'(8 * s); ca = 6'(8 * s + 4); fa = 6'(24 + 4 * s);
                m = msg_of(s, p);
                bus(snd, 1'b1, da, m[15:0], rv);
                chk("R3 no irq after data half", {host_irq, dsp_irq}, 0);
                bus(snd, 1'b1, ca, m[31:16], rv);
                chk("R3 receiver irq only", {host_irq, dsp_irq},
                    (s == 0) ? 32'd1 : 32'(1 << s));
                bus(1'b0, 1'b0, fa, 16'h0, rv);
                chk("R10 host flag", rv, 1);
                bus(1'b1, 1'b0, fa, 16'h0, rv);
                chk("R10 dsp flag", rv, 1);
                bus(rcv, 1'b0, da, 16'h0, rv);
                chk("R2 data half", rv, m[15:0]);
                chk("R5 data read keeps irq", {host_irq, dsp_irq},
                    (s == 0) ? 32'd1 : 32'(1 << s));
                bus(snd, 1'b0, ca, 16'h0, rv);
                chk("R8 sender cmd read value", rv, m[31:16]);
                chk("R8 sender cmd read keeps irq", {host_irq, dsp_irq},
                    (s == 0) ? 32'd1 : 32'(1 << s));
                bus(rcv, 1'b0, ca, 16'h0, rv);
                chk("R2 R4 cmd half", rv, m[31:16]);
                chk("R4 irq cleared", {host_irq, dsp_irq}, 0);
                bus(rcv, 1'b0, fa, 16'h0, rv);
                chk("R10 flag cleared", rv, 0);
            end
        end

        // R6: overwrite while pending on mailbox 1
        a_msg = 32'h1111_2222; b_msg = 32'h3333_4444;
        bus(1'b1, 1'b1, 6'h08, a_msg[15:0], rv);
        bus(1'b1, 1'b1, 6'h0C, a_msg[31:16], rv);
        bus(1'b1, 1'b1, 6'h08, b_msg[15:0], rv);
        bus(1'b1, 1'b1, 6'h0C, b_msg[31:16], rv);
        chk("R6 irq stays", host_irq, 2'b01);
        bus(1'b0, 1'b0, 6'h1C, 16'h0, rv);
        chk("R6 flag stays", rv, 1);
        bus(1'b0, 1'b0, 6'h08, 16'h0, rv);
        chk("R6 latest data", rv, b_msg[15:0]);
        bus(1'b0, 1'b0, 6'h0C, 16'h0, rv);
        chk("R6 latest cmd", rv, b_msg[31:16]);
        chk("R6 consumed", host_irq, 2'b00);

        // R7: wrong-side writes ignored
        bus(1'b0, 1'b1, 6'h08, 16'hDEAD, rv);
        bus(1'b0, 1'b1, 6'h0C, 16'hBEEF, rv);
        chk("R7 host irq", host_irq, 0);
        bus(1'b0, 1'b0, 6'h1C, 16'h0, rv);
        chk("R7 flag", rv, 0);
        bus(1'b0, 1'b0, 6'h08, 16'h0, rv);
        chk("R7 data kept", rv, b_msg[15:0]);
        bus(1'b0, 1'b0, 6'h0C, 16'h0, rv);
        chk("R7 cmd kept", rv, b_msg[31:16]);
        m = msg_of(0, 3);
        bus(1'b1, 1'b1, 6'h00, 16'hDEAD, rv);
        bus(1'b1, 1'b1, 6'h04, 16'hBEEF, rv);
        chk("R7 dsp irq", dsp_irq, 0);
        bus(1'b1, 1'b0, 6'h04, 16'h0, rv);
        chk("R7 mailbox 0 cmd kept", rv, m[31:16]);
        bus(1'b1, 1'b0, 6'h00, 16'h0, rv);
        chk("R7 mailbox 0 data kept", rv, m[15:0]);

        // R9: commit and consume in the same cycle
        c_msg = 32'hABCD_0123; d_msg = 32'h7777_8888;
        bus(1'b0, 1'b1, 6'h00, c_msg[15:0], rv);
        bus(1'b0, 1'b1, 6'h04, c_msg[31:16], rv);
        bus(1'b0, 1'b1, 6'h00, d_msg[15:0], rv);
        @(negedge clk);
        host_addr = 6'h04; host_wdata = d_msg[31:16]; host_wr = 1'b1;
        dsp_addr = 6'h04; dsp_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; dsp_rd = 1'b0;
        chk("R9 old cmd read", dsp_rdata, c_msg[31:16]);
        chk("R9 irq stays", dsp_irq, 1);
        bus(1'b1, 1'b0, 6'h00, 16'h0, rv);
        chk("R9 new data", rv, d_msg[15:0]);
        bus(1'b1, 1'b0, 6'h04, 16'h0, rv);
        chk("R9 new cmd", rv, d_msg[31:16]);
        chk("R9 then consumed", dsp_irq, 0);

        // R11: unaligned, out-of-map and flag writes have no effect
        bus(1'b0, 1'b1, 6'h06, 16'hFFFF, rv);
        bus(1'b0, 1'b1, 6'h02, 16'h5555, rv);
        bus(1'b0, 1'b1, 6'h30, 16'hFFFF, rv);
        bus(1'b0, 1'b1, 6'h18, 16'h0001, rv);
        bus(1'b1, 1'b1, 6'h1C, 16'h0001, rv);
        chk("R11 irqs untouched", {host_irq, dsp_irq}, 0);
        bus(1'b1, 1'b0, 6'h00, 16'h0, rv);
        chk("R11 data untouched", rv, d_msg[15:0]);
        bus(1'b0, 1'b0, 6'h30, 16'h0, rv);
        chk("R11 out-of-map read", rv, 0);
        bus(1'b0, 1'b0, 6'h05, 16'h0, rv);
        chk("R11 unaligned read", rv, 0);

        // R12: rdata holds between reads
        m = msg_of(2, 3);
        bus(1'b0, 1'b0, 6'h10, 16'h0, rv);
        chk("R12 read", rv, m[15:0]);
        repeat (5) @(negedge clk);
        chk("R12 hold", host_rdata, m[15:0]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule